// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the state of one downstream port of a USB root hub and presents it to host software as a single 32-bit register. When software reads the register, each implemented bit is a status flag. When software writes it, most of those same bit positions are command strobes: a 1 performs the command and a 0 does nothing. Software can power the port up or down, start a timed port reset, enable or suspend the port, and acknowledge the two change flags with write-one-to-clear.

Port power can be controlled per port or by global set and clear strobes. Two inputs decide which: a switching-mode bit and this port's mask bit. Three inputs from the port itself update the register on their own: the connect level, the device speed and an overcurrent indication. Enable and suspend are kept as plain status bits. Port reset lasts for a parameterized number of clock cycles. Line signalling is out of scope; the block only drives a port-reset-active output for it.

Top module: `rh_port_reg`

## Requirements
- R1: Bit 16 (connect change) is set whenever the connect status (bit 0) changes value. Writing 1 to bit 16 clears it, and writing 0 leaves it unchanged.
- R2: A write with bit 1 (enable), bit 2 (suspend) or bit 4 (reset) set has none of those effects while bit 0 reads 0. Instead, it sets bit 16.
- R3: While the device-removable input is high, connect changes do not set bit 16. A root-hub-reset-done pulse sets bit 16 if the port is connected.
- R4: Bit 9 reads 1 for a low-speed device and 0 for a full-speed device, and it reads 0 whenever bit 0 is 0. Writing 1 to bit 9 is the per-port clear-power command.
- R5: Bit 8 reads port power. A per-port write of 1 to bit 8 turns power on, and writing 0 there has no effect. An overcurrent input turns power off.
- R6: With the mode input at 0, or with mode at 1 and the mask input at 0, only the global set and clear strobes change power. With mode at 1 and mask at 1, only writes to bits 8 and 9 change power.
- R7: While power is off, bits 0, 1, 2 and 4 all read 0.
- R8: With the power-switch parameter at 0, bit 8 always reads 1.
- R9: Writing 1 to bit 4 on a connected port sets bit 4 for exactly RESET_CYCLES clock cycles. When the reset ends, bit 4 clears, bit 20 (reset change) is set and bit 1 (enabled) is set. Writing 1 to bit 20 clears bit 20.
- R10: Every bit other than 0 to 4, 8, 9, 16 and 20 reads 0, and writing to those bits has no effect. Bit 3 also reads 0.
- R11: If one write carries both the set-power and the clear-power command, power goes off. A connect change that lands in the same cycle as a write of 1 to bit 16 leaves bit 16 set.
- R12: On a connected port, writing 1 to bit 1 sets the enable flag (read at bit 1) and writing 1 to bit 0 clears it. Writing 1 to bit 2 sets the suspend flag (read at bit 2) and writing 1 to bit 3 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrData | input | 32 | Write data; each 1 bit is a command |
| rdData | output | 32 | Register read value |
| globalPwrSet | input | 1 | Hub-wide set-power strobe |
| globalPwrClr | input | 1 | Hub-wide clear-power strobe |
| pwrModePerPort | input | 1 | 1 selects per-port power switching |
| pwrMaskBit | input | 1 | This port's per-port power mask bit |
| devRemovable | input | 1 | Port carries a removable device |
| hubResetDone | input | 1 | One-cycle pulse at the end of a root hub reset |
| attachIn | input | 1 | Device present on the port |
| lowSpeedIn | input | 1 | Attached device is low speed |
| overCurrent | input | 1 | Overcurrent detected on the port |
| portResetActive | output | 1 | Port reset signalling in progress |

## Verification
The hardest cases to reach are collisions in a single cycle: a hardware connect change or reset completion landing in the same clock as the software write-one-to-clear aimed at the same flag. Another is the end of a port reset on a port that is still powered and connected. Directed sequences set these up on purpose. They hold attach steady across a reset of eight cycles, and they drop attach in the same cycle as a clear of bit 16. A long random phase follows. Its write bits are biased toward power-on and reset commands and away from clear-power and overcurrent, so resets often run to completion while connect toggles and write-one-to-clear writes land on random cycles.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

  localparam int BIT_CONN   = 0;   // read: connected, write: clear enable
  localparam int BIT_EN     = 1;   // read: enabled,   write: set enable
  localparam int BIT_SUSP   = 2;   // read: suspended, write: set suspend
  localparam int BIT_RESUME = 3;   // read: 0,         write: clear suspend
  localparam int BIT_RST    = 4;   // read: resetting, write: start reset
  localparam int BIT_PWR    = 8;   // read: powered,   write: set power
  localparam int BIT_LS     = 9;   // read: low speed, write: clear power
  localparam int BIT_CSC    = 16;  // connect change, write one to clear
  localparam int BIT_RSC    = 20;  // reset change,   write one to clear

  localparam logic [31:0] CMD_MASK =
    (32'd1 << BIT_CONN) | (32'd1 << BIT_EN) | (32'd1 << BIT_SUSP) |
    (32'd1 << BIT_RESUME) | (32'd1 << BIT_RST) | (32'd1 << BIT_PWR) |
    (32'd1 << BIT_LS) | (32'd1 << BIT_CSC) | (32'd1 << BIT_RSC);

  typedef struct packed {
    logic powerNext;
    logic linkNext;
    logic cscSet;
    logic cscClr;
    logic enSet;
    logic enClr;
    logic suspSet;
    logic suspClr;
    logic rstStart;
    logic rscClr;
  } portStrobe_t;

endpackage

// File: rtl/rh_port_ctrl.sv
module rh_port_ctrl
  import rh_port_pkg::*;
#(
  parameter bit PWR_SWITCH_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        globalPwrSet,
  input  logic        globalPwrClr,
  input  logic        pwrModePerPort,
  input  logic        pwrMaskBit,
  input  logic        devRemovable,
  input  logic        hubResetDone,
  input  logic        attachIn,
  input  logic        overCurrent,
  input  logic        curCcs,
  input  logic        curPps,
  input  logic        curPrs,
  output portStrobe_t stb
);

  logic perPort;
  logic pwrOn;
  logic pwrOff;
  logic refuse;
  logic linkEvent;
  logic wantEn;
  logic wantSusp;
  logic wantRst;

  assign perPort  = pwrModePerPort & pwrMaskBit;
  assign pwrOn    = perPort ? (wrEn & wrData[BIT_PWR]) : globalPwrSet;
  assign pwrOff   = perPort ? (wrEn & wrData[BIT_LS])  : globalPwrClr;

  assign wantEn   = wrEn & wrData[BIT_EN];
  assign wantSusp = wrEn & wrData[BIT_SUSP];
  assign wantRst  = wrEn & wrData[BIT_RST];
  assign refuse   = (wantEn | wantSusp | wantRst) & ~curCcs;

  always_comb begin
    stb = '0;
    if (!PWR_SWITCH_EN)   stb.powerNext = 1'b1;
    else if (overCurrent) stb.powerNext = 1'b0;
    else if (pwrOff)      stb.powerNext = 1'b0;
    else if (pwrOn)       stb.powerNext = 1'b1;
    else                  stb.powerNext = curPps;

    stb.linkNext = stb.powerNext & attachIn;
    linkEvent    = devRemovable ? (hubResetDone & stb.linkNext)
                                : (stb.linkNext != curCcs);

    stb.cscSet   = linkEvent | refuse;
    stb.cscClr   = wrEn & wrData[BIT_CSC];
    stb.rscClr   = wrEn & wrData[BIT_RSC];
    stb.enSet    = wantEn & curCcs;
    stb.enClr    = wrEn & wrData[BIT_CONN];
    stb.suspSet  = wantSusp & curCcs;
    stb.suspClr  = wrEn & wrData[BIT_RESUME];
    stb.rstStart = wantRst & curCcs & ~curPrs;
  end

  // R10
  reserved_write_inert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ((wrData & CMD_MASK) == 32'd0)) |->
      !(stb.enSet || stb.suspSet || stb.rstStart || stb.cscClr || stb.rscClr));

endmodule

// File: rtl/rh_port_datapath.sv
module rh_port_datapath
  import rh_port_pkg::*;
#(
  parameter int unsigned RESET_CYCLES  = 2_500_000,
  parameter bit          PWR_SWITCH_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  portStrobe_t stb,
  input  logic        lowSpeedIn,
  input  logic        overCurrent,
  output logic [31:0] rdData,
  output logic        ccs,
  output logic        pps,
  output logic        prs
);

  localparam int CW = (RESET_CYCLES > 2) ? $clog2(RESET_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RESET_CYCLES - 1);

  logic          pes;
  logic          pss;
  logic          lsda;
  logic          csc;
  logic          prsc;
  logic [CW-1:0] rstCnt;
  logic          rstDone;

  assign rstDone = prs & (rstCnt == LAST) & stb.linkNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pps    <= !PWR_SWITCH_EN;
      ccs    <= 1'b0;
      lsda   <= 1'b0;
      csc    <= 1'b0;
      pes    <= 1'b0;
      pss    <= 1'b0;
      prs    <= 1'b0;
      prsc   <= 1'b0;
      rstCnt <= '0;
    end else begin
      pps  <= stb.powerNext;
      ccs  <= stb.linkNext;
      lsda <= stb.linkNext & lowSpeedIn;

      if (stb.cscSet)      csc <= 1'b1;
      else if (stb.cscClr) csc <= 1'b0;

      if (rstDone)         prsc <= 1'b1;
      else if (stb.rscClr) prsc <= 1'b0;

      if (!stb.linkNext) begin
        pes    <= 1'b0;
        pss    <= 1'b0;
        prs    <= 1'b0;
        rstCnt <= '0;
      end else begin
        if (rstDone) begin
          prs <= 1'b0;
        end else if (prs) begin
          rstCnt <= rstCnt + 1'b1;
        end else if (stb.rstStart) begin
          prs    <= 1'b1;
          rstCnt <= '0;
        end

        if (rstDone)        pes <= 1'b1;
        else if (stb.enClr) pes <= 1'b0;
        else if (stb.enSet) pes <= 1'b1;

        if (stb.suspClr)      pss <= 1'b0;
        else if (stb.suspSet) pss <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[BIT_CONN] = ccs;
    rdData[BIT_EN]   = pes;
    rdData[BIT_SUSP] = pss;
    rdData[BIT_RST]  = prs;
    rdData[BIT_PWR]  = pps;
    rdData[BIT_LS]   = lsda;
    rdData[BIT_CSC]  = csc;
    rdData[BIT_RSC]  = prsc;
  end

  // R7
  power_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pps |-> !(ccs || pes || pss || prs));

  // R5
  overcurrent_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overCurrent && PWR_SWITCH_EN) |=> !pps);

  // R11
  csc_event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cscSet |=> csc);

  // R1
  csc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cscClr && !stb.cscSet) |=> !csc);

  // R2
  no_reset_unplugged_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ccs |=> !prs);

  // R9
  reset_end_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(prs) && ccs) |-> (prsc && pes));

endmodule

// File: rtl/rh_port_reg.sv
module rh_port_reg
  import rh_port_pkg::*;
#(
  parameter int unsigned RESET_CYCLES  = 2_500_000,
  parameter bit          PWR_SWITCH_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        globalPwrSet,
  input  logic        globalPwrClr,
  input  logic        pwrModePerPort,
  input  logic        pwrMaskBit,
  input  logic        devRemovable,
  input  logic        hubResetDone,
  input  logic        attachIn,
  input  logic        lowSpeedIn,
  input  logic        overCurrent,
  output logic        portResetActive
);

  portStrobe_t stb;
  logic        ccs;
  logic        pps;
  logic        prs;

  rh_port_ctrl #(
    .PWR_SWITCH_EN (PWR_SWITCH_EN)
  ) ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .wrEn           (wrEn),
    .wrData         (wrData),
    .globalPwrSet   (globalPwrSet),
    .globalPwrClr   (globalPwrClr),
    .pwrModePerPort (pwrModePerPort),
    .pwrMaskBit     (pwrMaskBit),
    .devRemovable   (devRemovable),
    .hubResetDone   (hubResetDone),
    .attachIn       (attachIn),
    .overCurrent    (overCurrent),
    .curCcs         (ccs),
    .curPps         (pps),
    .curPrs         (prs),
    .stb            (stb)
  );

  rh_port_datapath #(
    .RESET_CYCLES  (RESET_CYCLES),
    .PWR_SWITCH_EN (PWR_SWITCH_EN)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .lowSpeedIn  (lowSpeedIn),
    .overCurrent (overCurrent),
    .rdData      (rdData),
    .ccs         (ccs),
    .pps         (pps),
    .prs         (prs)
  );

  assign portResetActive = prs;

endmodule

// File: tb/rh_port_reg_tb_top.sv
`timescale 1ns/1ps
module rh_port_reg_tb_top;

  localparam int RST_LEN = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        gSet = 1'b0, gClr = 1'b0, mode = 1'b1, mask = 1'b1;
  logic        devRem = 1'b0, hubRst = 1'b0, attach = 1'b0, lowSpd = 1'b0, oc = 1'b0;
  logic [31:0] rd, rdNoSw;
  logic        rstAct, rstActNoSw;

  int nChecks = 0;
  int nFails  = 0;
  bit ended   = 1'b0;

  always #2 clk = ~clk;

  rh_port_reg #(.RESET_CYCLES(RST_LEN), .PWR_SWITCH_EN(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rd),
    .globalPwrSet(gSet), .globalPwrClr(gClr), .pwrModePerPort(mode),
    .pwrMaskBit(mask), .devRemovable(devRem), .hubResetDone(hubRst),
    .attachIn(attach), .lowSpeedIn(lowSpd), .overCurrent(oc),
    .portResetActive(rstAct));

  rh_port_reg #(.RESET_CYCLES(RST_LEN), .PWR_SWITCH_EN(1'b0)) dutNoSw_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdNoSw),
    .globalPwrSet(gSet), .globalPwrClr(gClr), .pwrModePerPort(mode),
    .pwrMaskBit(mask), .devRemovable(devRem), .hubResetDone(hubRst),
    .attachIn(attach), .lowSpeedIn(lowSpd), .overCurrent(oc),
    .portResetActive(rstActNoSw));

  // Reference model built from the requirements
  logic mCcs, mPes, mPss, mPrs, mPps, mLs, mCsc, mPrsc;
  int   mCnt;

  function automatic logic wb(int b);
    return wrEn & wrData[b];
  endfunction

  function automatic logic [31:0] expWord();
    logic [31:0] w = '0;
    w[0] = mCcs; w[1] = mPes; w[2] = mPss; w[4] = mPrs;
    w[8] = mPps; w[9] = mLs;  w[16] = mCsc; w[20] = mPrsc;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      {mCcs, mPes, mPss, mPrs, mPps, mLs, mCsc, mPrsc} = '0;
      mCnt = 0;
    end else begin
      logic perPort, setC, clrC, ppsN, ccsN, refuse, evt, done, start;
      perPort = mode & mask;
      setC    = perPort ? wb(8) : gSet;
      clrC    = perPort ? wb(9) : gClr;
      ppsN    = oc ? 1'b0 : clrC ? 1'b0 : setC ? 1'b1 : mPps;
      ccsN    = ppsN & attach;
      refuse  = (wb(1) | wb(2) | wb(4)) & ~mCcs;
      evt     = devRem ? (hubRst & ccsN) : (ccsN != mCcs);
      done    = mPrs && (mCnt == RST_LEN - 1) && ccsN;
      start   = wb(4) & mCcs & ~mPrs;
      mCsc    = (evt | refuse) ? 1'b1 : wb(16) ? 1'b0 : mCsc;
      mPrsc   = done ? 1'b1 : wb(20) ? 1'b0 : mPrsc;
      if (!ccsN) begin
        mPes = 0; mPss = 0; mPrs = 0; mCnt = 0;
      end else begin
        if (done) mPrs = 0;
        else if (mPrs) mCnt = mCnt + 1;
        else if (start) begin mPrs = 1; mCnt = 0; end
        mPes = done ? 1'b1 : wb(0) ? 1'b0 : (wb(1) & mCcs) ? 1'b1 : mPes;
        mPss = wb(3) ? 1'b0 : (wb(2) & mCcs) ? 1'b1 : mPss;
      end
      mPps = ppsN;
      mCcs = ccsN;
      mLs  = ccsN & lowSpd;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !ended) begin
      chk("model", rd, expWord());
      chk("R8", {31'd0, rdNoSw[8]}, 32'd1);
      chk("R9 reset output", {31'd0, rstAct}, {31'd0, mPrs});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doWrite(logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic finishUp();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rstN = 1'b1;
    chk("reset state", rd, 32'h0);
    chk("R8 reset", rdNoSw, 32'h0000_0100);

    // R2: reset on unconnected, unpowered port is refused
    doWrite(32'h0000_0010);  chk("R2", rd, 32'h0001_0000);
    doWrite(32'h0000_0000);  chk("R1 write zero", rd, 32'h0001_0000);
    doWrite(32'h0001_0000);  chk("R1 clear", rd, 32'h0);

    // R5: per-port power on; R1/R4 connect low speed
    doWrite(32'h0000_0100);  chk("R5 set", rd, 32'h0000_0100);
    attach = 1'b1; lowSpd = 1'b1;
    tick();                  chk("R4 low speed", rd, 32'h0001_0301);

    // R11: disconnect collides with clear of bit 16
    attach = 1'b0;
    doWrite(32'h0001_0000);  chk("R11 event wins", rd, 32'h0001_0100);
    attach = 1'b1; lowSpd = 1'b0;
    tick();
    doWrite(32'h0001_0000);  chk("R4 full speed", rd, 32'h0000_0101);

    // R12: enable and suspend commands
    doWrite(32'h0000_0002);  chk("R12 enable", rd, 32'h0000_0103);
    doWrite(32'h0000_0004);  chk("R12 suspend", rd, 32'h0000_0107);
    doWrite(32'h0000_0008);  chk("R12 resume", rd, 32'h0000_0103);
    doWrite(32'h0000_0001);  chk("R12 disable", rd, 32'h0000_0101);

    // R9: timed port reset
    doWrite(32'h0000_0010);  chk("R9 start", rd, 32'h0000_0111);
    repeat (RST_LEN - 1) tick();
    chk("R9 still active", rd, 32'h0000_0111);
    tick();                  chk("R9 done", rd, 32'h0010_0103);
    doWrite(32'h0010_0000);  chk("R9 clear change", rd, 32'h0000_0103);

    // R6: global strobes ignored in per-port mode with mask set
    gClr = 1'b1; tick(); gClr = 1'b0;
    chk("R6 global ignored", rd, 32'h0000_0103);
    mode = 1'b0;
    doWrite(32'h0000_0200);  chk("R6 port cmd ignored", rd, 32'h0000_0103);
    gClr = 1'b1; tick(); gClr = 1'b0;
    chk("R7 power off", rd, 32'h0001_0000);
    gSet = 1'b1; tick(); gSet = 1'b0;
    chk("R6 global on", rd, 32'h0001_0101);
    mode = 1'b1;
    doWrite(32'h0001_0000);  chk("R1 clear again", rd, 32'h0000_0101);
    mask = 1'b0;
    doWrite(32'h0000_0200);  chk("R6 mask clear", rd, 32'h0000_0101);
    mask = 1'b1;

    // R11: clear beats set in one write
    doWrite(32'h0000_0300);  chk("R11 clear wins", rd, 32'h0001_0000);
    doWrite(32'h0001_0100);  chk("R11 reconnect", rd, 32'h0001_0101);
    doWrite(32'h0001_0000);  chk("R1 clear third", rd, 32'h0000_0101);

    // R5: overcurrent
    oc = 1'b1; tick(); oc = 1'b0;
    chk("R5 overcurrent", rd, 32'h0001_0000);
    doWrite(32'h0001_0000);  chk("R1 clear fourth", rd, 32'h0);

    // R3: removable device reports only at hub reset
    devRem = 1'b1;
    doWrite(32'h0000_0100);  chk("R3 no change flag", rd, 32'h0000_0101);
    hubRst = 1'b1; tick(); hubRst = 1'b0;
    chk("R3 hub reset", rd, 32'h0001_0101);
    devRem = 1'b0;
    doWrite(32'h0001_0000);  chk("R3 cleared", rd, 32'h0000_0101);

    // R10: reserved bits
    doWrite(32'hFFEE_FCE0);  chk("R10 reserved", rd, 32'h0000_0101);

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] d;
      d = '0;
      d[0]  = ($urandom % 8)  == 0;
      d[1]  = ($urandom % 4)  == 0;
      d[2]  = ($urandom % 8)  == 0;
      d[3]  = ($urandom % 8)  == 0;
      d[4]  = ($urandom % 4)  == 0;
      d[8]  = ($urandom % 4)  == 0;
      d[9]  = ($urandom % 24) == 0;
      d[16] = ($urandom % 4)  == 0;
      d[20] = ($urandom % 4)  == 0;
      if (($urandom % 8) == 0) d = d | ($urandom & 32'hFFEE_FCE0);
      wrEn   = ($urandom % 2) == 0;
      wrData = d;
      gSet   = ($urandom % 16)  == 0;
      gClr   = ($urandom % 48)  == 0;
      hubRst = ($urandom % 32)  == 0;
      oc     = ($urandom % 200) == 0;
      lowSpd = $urandom % 2;
      if (($urandom % 64)  == 0) mode   = ~mode;
      if (($urandom % 64)  == 0) mask   = ~mask;
      if (($urandom % 24)  == 0) attach = ~attach;
      if (($urandom % 128) == 0) devRem = ~devRem;
      tick();
    end
    wrEn = 1'b0;
    tick();
    finishUp();
  end

endmodule